// File: doc/BRIEF.md
# Sector Hamming Syndrome Classifier

This block takes the 24-bit Hamming code that hardware computed while a 512-byte sector streamed past, together with the 24-bit code that was written to the spare area when the sector was programmed. Each code arrives as three bytes packed into one 24-bit word. On a check strobe the block XORs the two codes to form a syndrome and classifies it. The four classes are: clean, single-bit data error that can be repaired, uncorrectable, and a damaged code word. The result is registered. For a repairable error the block also reports which byte of the sector (0 to 511) and which bit inside that byte (0 to 7) flipped.

The classification uses the population count of the syndrome, which a balanced adder tree computes. The error location comes from the odd-numbered bits of the three syndrome bytes. Each column/row parity pair of a single-bit error has exactly one member set, and the odd member carries the address bit.

An optional repair path can be generated. The host feeds the buffer byte found at the reported address back into the block, and the block returns that byte with the faulty bit inverted. This avoids keeping a second copy of the address decode in the host logic.

Top module: `sector_ham_check`

## Requirements
- R1: `resValid` is high in exactly the cycle after a cycle in which `checkStb` was high, and the result outputs take their new values at that same clock edge.
- R2: The syndrome is `calcCode ^ storedCode`, with byte 0 in bits 7:0, byte 1 in bits 15:8 and byte 2 in bits 23:16. An all-zero syndrome gives `errClass` 0 (clean).
- R3: A syndrome with exactly 12 bits set gives `errClass` 1 (corrected).
- R4: When `errClass` is 1, `bitAddr` bits 0, 1, 2 equal syndrome byte 0 bits 1, 3, 5.
- R5: When `errClass` is 1, `byteAddr` bit 0 equals byte 0 bit 7. Bits 1..4 equal byte 1 bits 1, 3, 5, 7. Bits 5..8 equal byte 2 bits 1, 3, 5, 7.
- R6: A nonzero syndrome with fewer than 23 bits set and not exactly 12 gives `errClass` 2 (uncorrectable).
- R7: A syndrome with 23 or 24 bits set gives `errClass` 3 (code word error).
- R8: When `errClass` is not 1, `byteAddr` and `bitAddr` are zero.
- R9: Without a strobe, changes on `calcCode` and `storedCode` have no effect: all result outputs hold their last values.
- R10: `fixOut` equals `fixIn` with bit `bitAddr` inverted when `errClass` is 1, and equals `fixIn` otherwise.
- R11: After reset `errClass` is 0, both addresses are 0 and `resValid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| checkStb | input | 1 | Capture and classify the codes on this edge |
| calcCode | input | 24 | Code computed over the sector, byte 0 in bits 7:0 |
| storedCode | input | 24 | Code read from the spare area, same packing |
| fixIn | input | 8 | Buffer byte at the reported address |
| resValid | output | 1 | One-cycle pulse: new result present |
| errClass | output | 2 | 0 clean, 1 corrected, 2 uncorrectable, 3 code word error |
| byteAddr | output | 9 | Byte address of the flipped bit |
| bitAddr | output | 3 | Bit position of the flipped bit |
| fixOut | output | 8 | Repaired buffer byte |

## Verification
Syndromes built from a random sector address, with one member of every parity pair set, check the 12-count class and every address bit on its own. Random stored codes mostly fall in the uncorrectable class. Directed counts of 11, 13, 22, 23 and 24 set bits separate the 12-count test and the 23 threshold from nearby values. Equal codes check the clean class. Input changes without a strobe show that the registered result holds and that addresses are cleared outside the corrected class.

// File: rtl/sector_ham_pkg.sv
package sector_ham_pkg;

  typedef enum logic [1:0] {
    CLS_CLEAN   = 2'd0,
    CLS_FIXED   = 2'd1,
    CLS_UNCORR  = 2'd2,
    CLS_CODEERR = 2'd3
  } err_class_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
  } ctl_strobes_t;

endpackage

// File: rtl/sector_ham_ctrl.sv
module sector_ham_ctrl
  import sector_ham_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         checkStb,
  output ctl_strobes_t ctl,
  output logic         resValid
);

  always_comb begin
    ctl = '0;
    ctl.capture = checkStb;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= checkStb;
  end

endmodule

// File: rtl/sector_ham_popcount.sv
module sector_ham_popcount #(
  parameter int IN_W  = 24,
  localparam int CNT_W  = $clog2(IN_W + 1),
  localparam int LEAVES = 1 << $clog2(IN_W)
) (
  input  logic [IN_W-1:0]  vec,
  output logic [CNT_W-1:0] count
);

  // heap-ordered adder tree: node i sums nodes 2i+1 and 2i+2
  logic [CNT_W-1:0] node [0:2*LEAVES-2];

  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    if (k < IN_W) begin : g_used
      assign node[LEAVES-1+k] = CNT_W'(vec[k]);
    end else begin : g_pad
      assign node[LEAVES-1+k] = '0;
    end
  end

  for (genvar i = 0; i < LEAVES - 1; i++) begin : g_sum
    assign node[i] = node[2*i+1] + node[2*i+2];
  end

  assign count = node[0];

endmodule

// File: rtl/sector_ham_datapath.sv
module sector_ham_datapath
  import sector_ham_pkg::*;
#(
  parameter int CODE_BYTES = 3,
  parameter int BYTE_W     = 8,
  parameter int FIX_ONES   = 12,
  parameter int BAD_ONES   = 23,
  parameter bit HAS_FIX    = 1'b1,
  localparam int SYN_W     = CODE_BYTES * BYTE_W,
  localparam int CNT_W     = $clog2(SYN_W + 1),
  localparam int BIT_AW    = $clog2(BYTE_W),
  localparam int BYTE_AW   = 2 * CODE_BYTES + 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctl_strobes_t       ctl,
  input  logic [SYN_W-1:0]   calcCode,
  input  logic [SYN_W-1:0]   storedCode,
  input  logic [BYTE_W-1:0]  fixIn,
  output err_class_e         errClass,
  output logic [BYTE_AW-1:0] byteAddr,
  output logic [BIT_AW-1:0]  bitAddr,
  output logic [BYTE_W-1:0]  fixOut
);

  logic [SYN_W-1:0]   syndrome;
  logic [CNT_W-1:0]   onesCnt;
  logic [SYN_W/2-1:0] oddBits;
  err_class_e         nextClass;
  logic [BYTE_AW-1:0] nextByte;
  logic [BIT_AW-1:0]  nextBit;

  assign syndrome = calcCode ^ storedCode;

  sector_ham_popcount #(.IN_W(SYN_W)) u_pop (
    .vec   (syndrome),
    .count (onesCnt)
  );

  // odd member of each parity pair carries one address bit
  for (genvar p = 0; p < SYN_W / 2; p++) begin : g_odd
    assign oddBits[p] = syndrome[2*p+1];
  end

  always_comb begin
    if (syndrome == '0)                          nextClass = CLS_CLEAN;
    else if (onesCnt >= CNT_W'(BAD_ONES))        nextClass = CLS_CODEERR;
    else if (onesCnt == CNT_W'(FIX_ONES))        nextClass = CLS_FIXED;
    else                                         nextClass = CLS_UNCORR;
  end

  always_comb begin
    nextBit  = '0;
    nextByte = '0;
    if (nextClass == CLS_FIXED) begin
      nextBit  = oddBits[BIT_AW-1:0];
      nextByte = BYTE_AW'(oddBits[SYN_W/2-1:BIT_AW]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errClass <= CLS_CLEAN;
      byteAddr <= '0;
      bitAddr  <= '0;
    end else if (ctl.capture) begin
      errClass <= nextClass;
      byteAddr <= nextByte;
      bitAddr  <= nextBit;
    end
  end

  if (HAS_FIX) begin : g_fix
    logic [BYTE_W-1:0] flipMask;
    always_comb begin
      flipMask = '0;
      if (errClass == CLS_FIXED) flipMask[bitAddr] = 1'b1;
    end
    assign fixOut = fixIn ^ flipMask;
  end else begin : g_nofix
    assign fixOut = fixIn;
  end

endmodule

// File: rtl/sector_ham_check.sv
module sector_ham_check
  import sector_ham_pkg::*;
#(
  parameter bit HAS_FIX = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        checkStb,
  input  logic [23:0] calcCode,
  input  logic [23:0] storedCode,
  input  logic [7:0]  fixIn,
  output logic        resValid,
  output logic [1:0]  errClass,
  output logic [8:0]  byteAddr,
  output logic [2:0]  bitAddr,
  output logic [7:0]  fixOut
);

  ctl_strobes_t ctl;
  err_class_e   clsQ;

  sector_ham_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .checkStb (checkStb),
    .ctl      (ctl),
    .resValid (resValid)
  );

  sector_ham_datapath #(.HAS_FIX(HAS_FIX)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .calcCode   (calcCode),
    .storedCode (storedCode),
    .fixIn      (fixIn),
    .errClass   (clsQ),
    .byteAddr   (byteAddr),
    .bitAddr    (bitAddr),
    .fixOut     (fixOut)
  );

  assign errClass = clsQ;

endmodule

// File: rtl/sector_ham_check_sva.sv
module sector_ham_check_sva (
  input logic        clk,
  input logic        rstN,
  input logic        checkStb,
  input logic [23:0] calcCode,
  input logic [23:0] storedCode,
  input logic [7:0]  fixIn,
  input logic        resValid,
  input logic [1:0]  errClass,
  input logic [8:0]  byteAddr,
  input logic [2:0]  bitAddr,
  input logic [7:0]  fixOut
);

  AST_VALID_AFTER_STB: assert property (@(posedge clk) disable iff (!rstN)
    checkStb |=> resValid); // R1
  AST_VALID_NEEDS_STB: assert property (@(posedge clk) disable iff (!rstN)
    !checkStb |=> !resValid); // R1
  AST_EQUAL_IS_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (checkStb && calcCode == storedCode) |=> errClass == 2'd0); // R2
  AST_FULL_IS_CODEERR: assert property (@(posedge clk) disable iff (!rstN)
    (checkStb && $countones(calcCode ^ storedCode) >= 23) |=> errClass == 2'd3); // R7
  AST_ADDR_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    errClass != 2'd1 |-> (byteAddr == 9'd0 && bitAddr == 3'd0)); // R8
  AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rstN)
    !checkStb |=> ($stable(errClass) && $stable(byteAddr) && $stable(bitAddr))); // R9
  AST_FIX_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fixOut ^ fixIn)); // R10
  AST_FIX_PASS: assert property (@(posedge clk) disable iff (!rstN)
    errClass != 2'd1 |-> fixOut == fixIn); // R10

endmodule

bind sector_ham_check sector_ham_check_sva u_sva (
  .clk        (clk),
  .rstN       (rstN),
  .checkStb   (checkStb),
  .calcCode   (calcCode),
  .storedCode (storedCode),
  .fixIn      (fixIn),
  .resValid   (resValid),
  .errClass   (errClass),
  .byteAddr   (byteAddr),
  .bitAddr    (bitAddr),
  .fixOut     (fixOut)
);

// File: tb/tb_sector_ham_check.sv
module tb_sector_ham_check;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        checkStb = 1'b0;
  logic [23:0] calcCode = '0;
  logic [23:0] storedCode = '0;
  logic [7:0]  fixIn = '0;
  logic        resValid;
  logic [1:0]  errClass;
  logic [8:0]  byteAddr;
  logic [2:0]  bitAddr;
  logic [7:0]  fixOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sector_ham_check dut (
    .clk(clk), .rstN(rstN), .checkStb(checkStb), .calcCode(calcCode),
    .storedCode(storedCode), .fixIn(fixIn), .resValid(resValid),
    .errClass(errClass), .byteAddr(byteAddr), .bitAddr(bitAddr), .fixOut(fixOut)
  );

  function automatic int ones(input logic [23:0] s);
    int n = 0;
    for (int i = 0; i < 24; i++) n += int'(s[i]);
    return n;
  endfunction

  function automatic logic [1:0] expClass(input logic [23:0] s);
    int n = ones(s);
    if (s == '0) return 2'd0;    // R2
    if (n >= 23) return 2'd3;    // R7
    if (n == 12) return 2'd1;    // R3
    return 2'd2;                 // R6
  endfunction

  function automatic logic [2:0] expBit(input logic [23:0] s);
    if (expClass(s) != 2'd1) return 3'd0;
    return {s[5], s[3], s[1]};   // R4
  endfunction

  function automatic logic [8:0] expByte(input logic [23:0] s);
    if (expClass(s) != 2'd1) return 9'd0;
    return {s[23], s[21], s[19], s[17], s[15], s[13], s[11], s[9], s[7]}; // R5
  endfunction

  // syndrome of a genuine single-bit error at the given location
  function automatic logic [23:0] singleSyn(input logic [8:0] ba, input logic [2:0] bi);
    logic [11:0] a = {ba, bi};
    logic [23:0] s = '0;
    for (int p = 0; p < 12; p++) begin
      if (a[p]) s[2*p+1] = 1'b1;
      else      s[2*p]   = 1'b1;
    end
    return s;
  endfunction

  function automatic logic [23:0] synWithOnes(input int n);
    logic [23:0] s = '0;
    while (ones(s) < n) s[$urandom % 24] = 1'b1;
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runCase(input logic [23:0] calc, input logic [23:0] syn, input logic [7:0] fb);
    logic [1:0] ec;
    logic [8:0] eby;
    logic [2:0] ebi;
    logic [7:0] efix;
    @(negedge clk);
    calcCode   = calc;
    storedCode = calc ^ syn;
    fixIn      = fb;
    checkStb   = 1'b1;
    @(negedge clk);
    checkStb = 1'b0;
    ec  = expClass(syn);
    eby = expByte(syn);
    ebi = expBit(syn);
    efix = (ec == 2'd1) ? (fb ^ (8'd1 << ebi)) : fb;
    chk(resValid == 1'b1, "R1 valid", int'(resValid), 1);
    chk(errClass == ec, "R2/R3/R6/R7 class", int'(errClass), int'(ec));
    chk(byteAddr == eby, "R5/R8 byteAddr", int'(byteAddr), int'(eby));
    chk(bitAddr == ebi, "R4/R8 bitAddr", int'(bitAddr), int'(ebi));
    chk(fixOut == efix, "R10 fixOut", int'(fixOut), int'(efix));
  endtask

  // R9: inputs move without a strobe, results must hold
  task automatic idleCheck();
    logic [1:0] c0 = errClass;
    logic [8:0] b0 = byteAddr;
    logic [2:0] t0 = bitAddr;
    @(negedge clk);
    calcCode   = $urandom;
    storedCode = $urandom;
    @(negedge clk);
    chk(resValid == 1'b0, "R1 no valid without strobe", int'(resValid), 0);
    chk(errClass == c0, "R9 class held", int'(errClass), int'(c0));
    chk(byteAddr == b0 && bitAddr == t0, "R9 address held",
        int'({byteAddr, bitAddr}), int'({b0, t0}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(errClass == 2'd0, "R11 reset class", int'(errClass), 0);
    chk(byteAddr == 9'd0 && bitAddr == 3'd0, "R11 reset address", int'({byteAddr, bitAddr}), 0);
    chk(resValid == 1'b0, "R11 reset valid", int'(resValid), 0);
    rstN = 1'b1;

    // directed corners
    runCase(24'h5A3C96, 24'h000000, 8'hA5);              // R2 clean
    runCase(24'h123456, singleSyn(9'd0, 3'd0), 8'h00);   // R3 lowest location
    runCase(24'h0F0F0F, singleSyn(9'd511, 3'd7), 8'hFF); // R4 R5 highest location
    runCase(24'h000000, singleSyn(9'h155, 3'd5), 8'h3C); // R5 alternating
    runCase(24'hABCDEF, singleSyn(9'h0AA, 3'd2), 8'h81); // R5 other bits
    idleCheck();                                         // R9 after a fix
    runCase(24'h111111, synWithOnes(11), 8'h11);         // R6 below 12
    runCase(24'h222222, synWithOnes(13), 8'h22);         // R6 above 12
    runCase(24'h333333, synWithOnes(1), 8'h33);          // R6 single syndrome bit
    runCase(24'h444444, synWithOnes(22), 8'h44);         // R6 just under threshold
    runCase(24'h555555, synWithOnes(23), 8'h55);         // R7 threshold
    runCase(24'h666666, 24'hFFFFFF, 8'h66);              // R7 all ones
    idleCheck();                                         // R9 after code error
    runCase(24'h777777, 24'hFFF000, 8'h77);              // R3 twelve ones, not a real pair pattern

    for (int it = 0; it < 400; it++) begin
      logic [23:0] c = $urandom;
      logic [7:0]  f = $urandom;
      case ($urandom % 4)
        0: runCase(c, $urandom, f);
        1: runCase(c, singleSyn(9'($urandom), 3'($urandom)), f);
        2: runCase(c, 24'h0, f);
        default: runCase(c, synWithOnes(10 + int'($urandom % 15)), f);
      endcase
      if (it % 25 == 0) idleCheck();
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule